// File: doc/BRIEF.md
# Gated Seconds Timebase Counter

This block derives a one-second time base from a 32.768 kHz crystal clock and keeps a running seconds count from 0 to 59. Its outputs are a one-cycle strobe at each counted second and a one-cycle strobe at the rollover into a new minute. A clock's minute and hour logic consume these strobes.

Two user controls act on the seconds path. A time-setting input holds the seconds value at zero and stops second strobes while the user adjusts the time, but it does not stop the prescaler. A push-button input also zeroes the seconds, but only after an internal shift-register filter has read it high several times in a row. This filter rejects contact bounce.

Top module: `sectick_timebase`

## Requirements
- R1: The prescaler is a divide-by-DIV_LO stage (128 by default) feeding a divide-by-DIV_HI stage (256 by default). The raw tick repeats every DIV_LO*DIV_HI cycles (32768, which is one second at 32.768 kHz). The first tick appears in the cycle after DIV_LO*DIV_HI-1 rising edges with reset low.
- R2: `sec_strobe` and `min_strobe` are each high for exactly one clock cycle at a time, and `min_strobe` is never high without `sec_strobe`.
- R3: `secs` stays in the range 0 to 59. Each `sec_strobe` advances it by one on the following edge, and it wraps from 59 to 0.
- R4: `min_strobe` is high in the same cycle as the `sec_strobe` that moves `secs` from 59 to 0, and at no other time.
- R5: While `set_mode` is 1, `sec_strobe` and `min_strobe` stay 0 and `secs` is forced to 0 from the first edge on which `set_mode` is sampled high.
- R6: `set_mode` does not stop the prescaler. After `set_mode` is released, strobes stay aligned to the tick phase that was running before it, so the spacing between any two strobes is a whole multiple of the tick period.
- R7: `zero_btn` is sampled once every DIV_LO cycles into a DB_DEPTH-stage shift register (4 stages by default). It takes effect only once all stages hold 1, so a press that covers fewer samples leaves `secs` unchanged.
- R8: While the filtered button is active, `secs` is held at 0 and `min_strobe` is suppressed.
- R9: Synchronous active-high `rst` clears the prescaler, the filter and `secs` to zero, and both strobes read 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| set_mode | input | 1 | Time-setting mode; blocks seconds and zeroes them |
| zero_btn | input | 1 | Raw seconds-zero push button |
| secs | output | 6 | Current seconds value, 0 to 59 |
| sec_strobe | output | 1 | One-cycle pulse per counted second |
| min_strobe | output | 1 | One-cycle pulse at the 59-to-0 rollover |

## Verification
The assertions check these properties on every cycle: the divider counters stay within bounds, the tick is never wider than one cycle, `secs` never leaves 0 to 59, it holds when no strobe or clear is present, a rollover is always followed by zero, and a minute strobe never appears alone. Some behaviour can only be shown by the bench scenarios. These are the exact tick period and first-tick position after reset, and whether the prescaler phase survives a time-setting interval. They also include whether a press that is too short is truly ignored while one held over four samples zeroes the count.

// File: rtl/sectick_pkg.sv
package sectick_pkg;

    localparam int SEC_W   = 6;
    localparam int SEC_MOD = 60;

    typedef logic [SEC_W-1:0] sec_t;

    localparam sec_t SEC_LAST = sec_t'(SEC_MOD - 1);

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_CLEAR = 2'd2
    } sec_act_e;

    typedef struct packed {
        logic sec;
        logic wrap;
    } strobe_t;

    function automatic sec_t sec_advance(input sec_t cur);
        return (cur == SEC_LAST) ? '0 : cur + sec_t'(1);
    endfunction

    function automatic sec_act_e pick_action(input logic blocked,
                                             input logic zeroed,
                                             input logic tick);
        if (blocked || zeroed) return ACT_CLEAR;
        if (tick)              return ACT_STEP;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/sectick_divstage.sv
module sectick_divstage #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic en_in,
    output logic pulse
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en_in) begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        end
    end

    assign pulse = en_in && (cnt == LAST);

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/sectick_prescaler.sv
module sectick_prescaler #(
    parameter int DIV_LO = 128,
    parameter int DIV_HI = 256
) (
    input  logic clk,
    input  logic rst,
    output logic sample_en,
    output logic tick
);
    localparam int NSTAGE = 2;
    localparam int DIVS [NSTAGE] = '{DIV_LO, DIV_HI};

    logic [NSTAGE:0] chain;
    assign chain[0] = 1'b1;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        sectick_divstage #(.DIV(DIVS[g])) u_div (
            .clk   (clk),
            .rst   (rst),
            .en_in (chain[g]),
            .pulse (chain[g+1])
        );
    end

    assign sample_en = chain[1];
    assign tick      = chain[NSTAGE];

    assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/sectick_debounce.sv
module sectick_debounce #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic btn,
    output logic hit
);
    logic [DEPTH-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (sample_en) begin
            shreg <= {shreg[DEPTH-2:0], btn};
        end
    end

    assign hit = &shreg;

    assert_hit_on_sample_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hit) |-> $past(sample_en));

endmodule

// File: rtl/sectick_modcount.sv
module sectick_modcount
    import sectick_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic blocked,
    input  logic zeroed,
    output sec_t secs,
    output strobe_t strb
);
    sec_act_e act;

    always_comb begin
        act      = pick_action(blocked, zeroed, tick);
        strb.sec = tick && !blocked;
        strb.wrap = (act == ACT_STEP) && (secs == SEC_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            secs <= '0;
        end else begin
            unique case (act)
                ACT_STEP:  secs <= sec_advance(secs);
                ACT_CLEAR: secs <= '0;
                default:   secs <= secs;
            endcase
        end
    end

    assert_secs_range_R3: assert property (@(posedge clk) disable iff (rst)
        secs <= SEC_LAST);

    assert_secs_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !blocked && !zeroed) |=> $stable(secs));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
        strb.wrap |=> (secs == '0));

    assert_min_with_sec_R2: assert property (@(posedge clk) disable iff (rst)
        strb.wrap |-> strb.sec);

    assert_blocked_zero_R5: assert property (@(posedge clk) disable iff (rst)
        blocked |=> (secs == '0));

    assert_btn_zero_R8: assert property (@(posedge clk) disable iff (rst)
        zeroed |=> (secs == '0));

endmodule

// File: rtl/sectick_timebase.sv
module sectick_timebase
    import sectick_pkg::*;
#(
    parameter int DIV_LO   = 128,
    parameter int DIV_HI   = 256,
    parameter int DB_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_mode,
    input  logic       zero_btn,
    output logic [5:0] secs,
    output logic       sec_strobe,
    output logic       min_strobe
);
    logic    sample_en;
    logic    raw_tick;
    logic    btn_hit;
    sec_t    sec_val;
    strobe_t strb;

    sectick_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .tick      (raw_tick)
    );

    sectick_debounce #(.DEPTH(DB_DEPTH)) u_deb (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .btn       (zero_btn),
        .hit       (btn_hit)
    );

    sectick_modcount u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (raw_tick),
        .blocked (set_mode),
        .zeroed  (btn_hit),
        .secs    (sec_val),
        .strb    (strb)
    );

    assign secs       = sec_val;
    assign sec_strobe = strb.sec;
    assign min_strobe = strb.wrap;

    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
        set_mode |-> !sec_strobe);

    assert_min_width_R2: assert property (@(posedge clk) disable iff (rst)
        min_strobe |=> !min_strobe);

endmodule

// File: tb/sectick_timebase_tb.sv
module sectick_timebase_tb;

    localparam int DA  = 4;
    localparam int DB  = 8;
    localparam int PER = DA * DB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       set_mode = 1'b0;
    logic       zero_btn = 1'b0;
    logic [5:0] secs;
    logic       sec_strobe;
    logic       min_strobe;

    always #2 clk = ~clk;

    sectick_timebase #(.DIV_LO(DA), .DIV_HI(DB), .DB_DEPTH(4)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .set_mode   (set_mode),
        .zero_btn   (zero_btn),
        .secs       (secs),
        .sec_strobe (sec_strobe),
        .min_strobe (min_strobe)
    );

    typedef struct {
        int s;
        bit m;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   ncyc = 0;
    int   nstr = 0;
    int   last_t = -1;
    int   rel_t = 0;
    bit   first_rel = 0;
    bit   pend = 0;
    int   pend_s = 0;
    bit   prev_rst = 1;
    bit   prev_sec = 0;
    bit   prev_min = 0;
    bit   armed = 0;
    int   model = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops expectations on each strobe and compares
    always @(negedge clk) begin
        ncyc++;
        if (armed && !rst) begin
            if (prev_rst) begin
                rel_t     = ncyc;
                first_rel = 1;
                last_t    = -1;
            end
            if (pend) begin
                chk(secs == 6'(pend_s), "R3 secs after strobe", int'(secs), pend_s);
                pend = 0;
            end
            if (min_strobe && !sec_strobe) chk(0, "R2 lone minute strobe", 1, 0);
            if (min_strobe && prev_min) chk(0, "R2 minute strobe width", 2, 1);
            if (sec_strobe) begin
                nstr++;
                chk(!prev_sec, "R2 second strobe width", int'(prev_sec) + 1, 1);
                if (first_rel)
                    chk(ncyc - rel_t == PER - 2, "R1 first tick position", ncyc - rel_t, PER - 2);
                else if (last_t >= 0)
                    chk((ncyc - last_t) % PER == 0, "R1 R6 tick spacing", ncyc - last_t, PER);
                first_rel = 0;
                last_t = ncyc;
                if (q.size() == 0) begin
                    chk(0, "R5 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(min_strobe == e.m, "R4 minute strobe", int'(min_strobe), int'(e.m));
                    pend   = 1;
                    pend_s = e.s;
                end
            end
        end
        prev_rst = rst;
        prev_sec = sec_strobe;
        prev_min = min_strobe;
    end

    task automatic run_secs(input int n);
        int target;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.s = (model + 1) % 60;
            e.m = (model == 59);
            q.push_back(e);
            model = (model + 1) % 60;
        end
        target = nstr + n;
        wait (nstr >= target);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(secs == 6'd0, "R9 reset secs", int'(secs), 0);
        chk(!sec_strobe && !min_strobe, "R9 reset strobes", int'(sec_strobe), 0);
        armed = 1;
        rst <= 1'b0;

        // R3 R4: count past a full minute
        run_secs(65);

        // R5 R6: time-setting mode
        @(negedge clk);
        set_mode <= 1'b1;
        @(negedge clk);
        chk(secs == 6'd0, "R5 cleared on entry", int'(secs), 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            chk(secs == 6'd0 && !sec_strobe && !min_strobe, "R5 held in set mode", int'(secs), 0);
        end
        set_mode <= 1'b0;
        model = 0;
        run_secs(3);

        // R7: press shorter than four samples has no effect
        @(negedge clk);
        zero_btn <= 1'b1;
        repeat (10) @(negedge clk);
        zero_btn <= 1'b0;
        repeat (9) @(negedge clk);
        chk(secs == 6'(model), "R7 short press ignored", int'(secs), model);
        run_secs(2);

        // R7 R8: press held across four samples zeroes the count
        @(negedge clk);
        zero_btn <= 1'b1;
        repeat (18) @(negedge clk);
        chk(secs == 6'd0, "R8 filtered press zeroes", int'(secs), 0);
        zero_btn <= 1'b0;
        model = 0;
        run_secs(2);

        // R9: reset in mid-run, then R1 first tick again
        repeat (5) @(negedge clk);
        rst <= 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(secs == 6'd0, "R9 mid-run reset", int'(secs), 0);
        chk(!sec_strobe, "R9 no strobe in reset", int'(sec_strobe), 0);
        q.delete();
        pend  = 0;
        model = 0;
        rst <= 1'b0;
        run_secs(2);
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule